// File: doc/BRIEF.md
# Link Virtual-Channel Grant Allocator

This block is the output side of one link in a three-dimensional torus router. Several input units each present the head of a waiting packet: a request flag, a traffic class and a length in 32-byte chunks. Every cycle the allocator picks at most one of these heads. It also picks the virtual channel that head will travel on. It then issues a registered grant. Heads that are not granted stay at their inputs and ask again.

The link carries four virtual channels. Channels 0 and 1 serve adaptively routed traffic. Channel 2 is the deterministic escape channel, which keeps the adaptive sub-network deadlock free. Channel 3 is reserved for high-priority packets. Each channel has a token counter that stands for free 32-byte slots in the neighbour's buffer. A head is granted only when its channel can absorb the whole packet, which gives virtual cut-through behaviour. The tokens are taken at grant time. The neighbour returns tokens one at a time through a return pulse that names a channel.

After a grant the link is occupied for one cycle per chunk of the granted packet. The allocator makes no new grant until that time has passed.

Top module: `ovc_alloc`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `grant_valid` is 0 and every channel's token count equals `DEPTH`.
- R2: A head is granted only if its target channel holds at least `req_len+1` tokens (the length field encodes 1 to 8 chunks as 0 to 7). In the cycle `grant_valid` is high, that channel's count has already dropped by exactly that amount. An exact fit is granted.
- R3: A class-2 (priority) request that fits in channel 3 is granted ahead of any other class.
- R4: Requests at the same level are served round-robin. After input i is granted, the search starts at input i+1 and wraps around.
- R5: A class-0 (adaptive) head takes channel 1 only when channel 1 holds strictly more tokens than channel 0. Otherwise it takes channel 0.
- R6: An adaptive head moves to channel 2 only when neither adaptive channel can hold it. It waits if channel 2 cannot hold it either.
- R7: A grant of n chunks is followed by no other grant in the next n-1 cycles. With requests pending and tokens available, the next grant comes exactly n cycles later, so 1-chunk packets are granted back to back.
- R8: A return pulse adds one token to the channel it names (`ret_vc` 0 to 3). A count already at `DEPTH` stays at `DEPTH`.
- R9: A class-1 head, and a class-3 head (treated the same way), uses only channel 2. A class-2 head uses only channel 3.
- R10: A head whose channel lacks tokens does not block other inputs. An eligible head on another input is granted in its place. A grant only goes to an input that was requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_IN | Head present at each input |
| req_class | input | 2*N_IN | Class per input, 2 bits each: 0 adaptive, 1 escape, 2 priority, 3 escape |
| req_len | input | 3*N_IN | Chunk count minus one per input, 3 bits each |
| ret_valid | input | 1 | Token return pulse from the neighbour |
| ret_vc | input | 2 | Channel that receives the returned token |
| grant_valid | output | 1 | One-cycle grant pulse |
| grant_idx | output | IDX_W | Granted input |
| grant_vc | output | 2 | Channel assigned to the granted packet |
| grant_len | output | 3 | Chunk count minus one of the granted packet |
| vc_tokens | output | 4*TOK_W | Token count per channel, channel 0 in the low bits |

## Verification
The bench targets the token boundaries.

- **Exact fit.** A packet that needs exactly the tokens left must be granted. An off-by-one compare would stall it, or would let a channel go below zero and overrun the neighbour.
- **Adaptive channel choice.** The bench covers the tie between the two adaptive channels and the case where only one of them is full. A design that compares the wrong way would pile traffic onto one channel. A design that falls back too early would spend the escape channel on packets that fit adaptively.
- **Link occupancy.** The bench measures the spacing after 8-chunk and 1-chunk grants. This exposes an occupancy counter that is one cycle long or short.
- **Saturated return and starved escape.** A saturating return must not wrap the count. A starved escape head must not freeze the other inputs.

// File: rtl/ovc_pkg.sv
package ovc_pkg;
   localparam int N_VC  = 4;
   localparam int LEN_W = 3;
   localparam int MAX_CHUNKS = 1 << LEN_W;

   localparam logic [1:0] CLS_ADAPT = 2'd0;
   localparam logic [1:0] CLS_ESC   = 2'd1;
   localparam logic [1:0] CLS_PRIO  = 2'd2;
   localparam logic [1:0] CLS_ESC2  = 2'd3;

   localparam logic [1:0] VC_ADAPT_A = 2'd0;
   localparam logic [1:0] VC_ADAPT_B = 2'd1;
   localparam logic [1:0] VC_ESCAPE  = 2'd2;
   localparam logic [1:0] VC_PRIO    = 2'd3;
endpackage

// File: rtl/ovc_vc_select.sv
// Per-input channel choice and eligibility against current token counts.
module ovc_vc_select
   import ovc_pkg::*;
#(
   parameter int TOK_W = 5
) (
   input  logic                    valid,
   input  logic [1:0]              cls,
   input  logic [LEN_W-1:0]        len,
   input  logic [N_VC*TOK_W-1:0]   tokens,
   output logic                    elig,
   output logic                    hi,
   output logic [1:0]              vc
);
   logic [TOK_W-1:0] need;
   logic [TOK_W-1:0] t_a, t_b, t_esc, t_pri, t_best;
   logic             b_wins;

   always_comb begin
      need   = TOK_W'(len) + TOK_W'(1);
      t_a    = tokens[0*TOK_W +: TOK_W];
      t_b    = tokens[1*TOK_W +: TOK_W];
      t_esc  = tokens[2*TOK_W +: TOK_W];
      t_pri  = tokens[3*TOK_W +: TOK_W];
      b_wins = t_b > t_a;
      t_best = b_wins ? t_b : t_a;
      hi     = valid && (cls == CLS_PRIO);
      elig   = 1'b0;
      vc     = VC_ESCAPE;
      case (cls)
         CLS_ADAPT: begin
            if (t_best >= need) begin
               vc   = b_wins ? VC_ADAPT_B : VC_ADAPT_A;
               elig = valid;
            end else begin
               vc   = VC_ESCAPE;
               elig = valid && (t_esc >= need);
            end
         end
         CLS_PRIO: begin
            vc   = VC_PRIO;
            elig = valid && (t_pri >= need);
         end
         default: begin
            vc   = VC_ESCAPE;
            elig = valid && (t_esc >= need);
         end
      endcase
   end
endmodule

// File: rtl/ovc_rr_arbiter.sv
// Round-robin pick over a request mask, search starting at ptr.
module ovc_rr_arbiter #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]     mask,
   input  logic [IDX_W-1:0] ptr,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int k = 0; k < N; k++) begin
         int p;
         p = (int'(ptr) + k) % N;
         if (!found && mask[p]) begin
            found = 1'b1;
            idx   = IDX_W'(p);
         end
      end
   end
endmodule

// File: rtl/ovc_token_bank.sv
// One saturating token counter per virtual channel.
module ovc_token_bank
   import ovc_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int TOK_W = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  dec_en,
   input  logic [1:0]            dec_vc,
   input  logic [TOK_W-1:0]      dec_amt,
   input  logic                  ret_en,
   input  logic [1:0]            ret_vc,
   output logic [N_VC*TOK_W-1:0] tokens
);
   localparam logic [TOK_W:0]   CAP  = (TOK_W+1)'(DEPTH);
   localparam logic [TOK_W-1:0] FULL = TOK_W'(DEPTH);

   for (genvar v = 0; v < N_VC; v++) begin : g_vc
      logic [TOK_W-1:0] cnt;
      logic [TOK_W:0]   sum;
      logic             dec_hit, ret_hit;

      always_comb begin
         dec_hit = dec_en && (dec_vc == 2'(v));
         ret_hit = ret_en && (ret_vc == 2'(v));
         sum     = {1'b0, cnt}
                 - (dec_hit ? {1'b0, dec_amt} : '0)
                 + (ret_hit ? (TOK_W+1)'(1) : '0);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        cnt <= FULL;
         else if (sum > CAP) cnt <= FULL;
         else               cnt <= sum[TOK_W-1:0];
      end

      assign tokens[v*TOK_W +: TOK_W] = cnt;
   end
endmodule

// File: rtl/ovc_alloc.sv
module ovc_alloc
   import ovc_pkg::*;
#(
   parameter  int N_IN  = 4,
   parameter  int DEPTH = 16,
   localparam int IDX_W = $clog2(N_IN),
   localparam int TOK_W = $clog2(DEPTH + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_IN-1:0]         req_valid,
   input  logic [2*N_IN-1:0]       req_class,
   input  logic [3*N_IN-1:0]       req_len,
   input  logic                    ret_valid,
   input  logic [1:0]              ret_vc,
   output logic                    grant_valid,
   output logic [IDX_W-1:0]        grant_idx,
   output logic [1:0]              grant_vc,
   output logic [2:0]              grant_len,
   output logic [4*TOK_W-1:0]      vc_tokens
);
   if (N_IN < 2) begin : g_chk_n
      $error("ovc_alloc: N_IN must be at least 2");
   end
   if (DEPTH < MAX_CHUNKS) begin : g_chk_depth
      $error("ovc_alloc: DEPTH must hold one maximum-length packet");
   end

   logic [N_IN-1:0]   elig, is_hi, hi_mask, use_mask;
   logic [1:0]        cand_vc [N_IN];
   logic              arb_found, do_grant, link_free;
   logic [IDX_W-1:0]  arb_idx, rr_ptr, ptr_next;
   logic [1:0]        sel_vc;
   logic [2:0]        sel_len, busy;

   for (genvar i = 0; i < N_IN; i++) begin : g_in
      ovc_vc_select #(.TOK_W(TOK_W)) u_sel (
         .valid  (req_valid[i]),
         .cls    (req_class[2*i +: 2]),
         .len    (req_len[3*i +: 3]),
         .tokens (vc_tokens),
         .elig   (elig[i]),
         .hi     (is_hi[i]),
         .vc     (cand_vc[i])
      );
   end

   always_comb begin
      hi_mask  = elig & is_hi;
      use_mask = (|hi_mask) ? hi_mask : elig;
   end

   ovc_rr_arbiter #(.N(N_IN), .IDX_W(IDX_W)) u_arb (
      .mask  (use_mask),
      .ptr   (rr_ptr),
      .found (arb_found),
      .idx   (arb_idx)
   );

   always_comb begin
      link_free = (busy == 3'd0);
      do_grant  = arb_found && link_free;
      sel_vc    = cand_vc[arb_idx];
      sel_len   = req_len[int'(arb_idx)*3 +: 3];
      ptr_next  = (int'(arb_idx) == N_IN - 1) ? '0 : arb_idx + IDX_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_valid <= 1'b0;
         grant_idx   <= '0;
         grant_vc    <= '0;
         grant_len   <= '0;
         rr_ptr      <= '0;
         busy        <= '0;
      end else begin
         grant_valid <= do_grant;
         if (do_grant) begin
            grant_idx <= arb_idx;
            grant_vc  <= sel_vc;
            grant_len <= sel_len;
            rr_ptr    <= ptr_next;
            busy      <= sel_len;
         end else if (busy != 3'd0) begin
            busy <= busy - 3'd1;
         end
      end
   end

   ovc_token_bank #(.DEPTH(DEPTH), .TOK_W(TOK_W)) u_tok (
      .clk     (clk),
      .rst_n   (rst_n),
      .dec_en  (do_grant),
      .dec_vc  (sel_vc),
      .dec_amt (TOK_W'(sel_len) + TOK_W'(1)),
      .ret_en  (ret_valid),
      .ret_vc  (ret_vc),
      .tokens  (vc_tokens)
   );
endmodule

// File: rtl/ovc_alloc_chk.sv
module ovc_alloc_chk
   import ovc_pkg::*;
#(
   parameter int N_IN  = 4,
   parameter int DEPTH = 16,
   parameter int IDX_W = 2,
   parameter int TOK_W = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic [N_IN-1:0]     req_valid,
   input logic [2*N_IN-1:0]   req_class,
   input logic [3*N_IN-1:0]   req_len,
   input logic                grant_valid,
   input logic [IDX_W-1:0]    grant_idx,
   input logic [1:0]          grant_vc,
   input logic [2:0]          grant_len,
   input logic [4*TOK_W-1:0]  vc_tokens
);
   logic [N_IN-1:0]    p_valid;
   logic [2*N_IN-1:0]  p_class;
   logic [3*N_IN-1:0]  p_len;
   logic [4*TOK_W-1:0] p_tok;
   logic [1:0]         g_cls;
   logic               g_req, g_fit, hi_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_valid <= '0;
         p_class <= '0;
         p_len   <= '0;
         p_tok   <= {4{TOK_W'(DEPTH)}};
      end else begin
         p_valid <= req_valid;
         p_class <= req_class;
         p_len   <= req_len;
         p_tok   <= vc_tokens;
      end
   end

   always_comb begin
      g_cls   = p_class[int'(grant_idx)*2 +: 2];
      g_req   = p_valid[grant_idx];
      g_fit   = p_tok[int'(grant_vc)*TOK_W +: TOK_W] >= (TOK_W'(grant_len) + TOK_W'(1));
      hi_pend = 1'b0;
      for (int i = 0; i < N_IN; i++) begin
         if (p_valid[i] && p_class[2*i +: 2] == CLS_PRIO &&
             (TOK_W'(p_len[3*i +: 3]) + TOK_W'(1)) <= p_tok[3*TOK_W +: TOK_W])
            hi_pend = 1'b1;
      end
   end

   assert_fit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> g_fit);

   assert_prio_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && g_cls != CLS_PRIO) |-> !hi_pend);

   assert_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && grant_len != 3'd0) |=> !grant_valid);

   for (genvar v = 0; v < 4; v++) begin : g_cap
      assert_tok_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
         vc_tokens[v*TOK_W +: TOK_W] <= TOK_W'(DEPTH));
   end

   assert_class_vc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> ((g_cls == CLS_PRIO) ? (grant_vc == VC_PRIO)
                     : (g_cls == CLS_ADAPT) ? (grant_vc != VC_PRIO)
                     : (grant_vc == VC_ESCAPE)));

   assert_granted_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> g_req);
endmodule

bind ovc_alloc ovc_alloc_chk #(.N_IN(N_IN), .DEPTH(DEPTH), .IDX_W(IDX_W), .TOK_W(TOK_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_class   (req_class),
   .req_len     (req_len),
   .grant_valid (grant_valid),
   .grant_idx   (grant_idx),
   .grant_vc    (grant_vc),
   .grant_len   (grant_len),
   .vc_tokens   (vc_tokens)
);

// File: tb/sim_ovc_alloc.sv
`timescale 1ns/1ps
module sim_ovc_alloc;
   localparam int N_IN  = 4;
   localparam int DEPTH = 16;
   localparam int IDX_W = 2;
   localparam int TOK_W = 5;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [N_IN-1:0]   req_valid;
   logic [2*N_IN-1:0] req_class;
   logic [3*N_IN-1:0] req_len;
   logic              ret_valid;
   logic [1:0]        ret_vc;
   logic              grant_valid;
   logic [IDX_W-1:0]  grant_idx;
   logic [1:0]        grant_vc;
   logic [2:0]        grant_len;
   logic [4*TOK_W-1:0] vc_tokens;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   ovc_alloc #(.N_IN(N_IN), .DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
      .req_len(req_len), .ret_valid(ret_valid), .ret_vc(ret_vc),
      .grant_valid(grant_valid), .grant_idx(grant_idx), .grant_vc(grant_vc),
      .grant_len(grant_len), .vc_tokens(vc_tokens)
   );

   typedef struct packed {
      logic [3:0]  v;
      logic [7:0]  cls;
      logic [11:0] len;
      logic        g;
      logic [1:0]  idx;
      logic [1:0]  vc;
   } vec_t;

   // Each row is applied alone right after reset (all channels full).
   localparam vec_t VECS [7] = '{
      '{4'b0001, 8'h00, 12'h003, 1'b1, 2'd0, 2'd0},  // R5 tie -> channel 0
      '{4'b0011, 8'h08, 12'h000, 1'b1, 2'd1, 2'd3},  // R3 priority beats pointer
      '{4'b1111, 8'h55, 12'h000, 1'b1, 2'd0, 2'd2},  // R4 pointer at 0, R9 escape
      '{4'b0100, 8'h30, 12'h000, 1'b1, 2'd2, 2'd2},  // R9 class 3 on escape
      '{4'b1100, 8'hA0, 12'h700, 1'b1, 2'd2, 2'd3},  // R3 two priority heads, R4
      '{4'b0000, 8'h00, 12'h000, 1'b0, 2'd0, 2'd0},  // R10 nothing requested
      '{4'b1010, 8'h40, 12'h000, 1'b1, 2'd1, 2'd0}   // R4 first from pointer
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int tok(input int v);
      return int'(vc_tokens[v*TOK_W +: TOK_W]);
   endfunction

   task automatic idle_inputs();
      req_valid = '0; req_class = '0; req_len = '0;
      ret_valid = 1'b0; ret_vc = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      idle_inputs();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Present one head and wait for its grant; returns edges waited.
   task automatic send(input int i, input logic [1:0] c, input logic [2:0] l, output int waited);
      req_valid[i] = 1'b1;
      req_class[2*i +: 2] = c;
      req_len[3*i +: 3] = l;
      waited = 0;
      do begin
         @(posedge clk); @(negedge clk);
         waited++;
      end while (!grant_valid && waited < 40);
      req_valid[i] = 1'b0;
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog (all requirements): got hung run expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int w;
      rst_n = 1'b0;
      idle_inputs();

      // Table walk
      foreach (VECS[k]) begin
         do_reset();
         req_valid = VECS[k].v; req_class = VECS[k].cls; req_len = VECS[k].len;
         @(posedge clk); @(negedge clk);
         chk($sformatf("R3/R4/R9 vec%0d grant", k), int'(grant_valid), int'(VECS[k].g));
         if (VECS[k].g) begin
            chk($sformatf("R4 vec%0d idx", k), int'(grant_idx), int'(VECS[k].idx));
            chk($sformatf("R9 vec%0d vc", k), int'(grant_vc), int'(VECS[k].vc));
         end
         idle_inputs();
      end

      // R1 reset state
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      chk("R1 grant in reset", int'(grant_valid), 0);
      rst_n = 1'b1;
      chk("R1 grant after release", int'(grant_valid), 0);
      for (int v = 0; v < 4; v++) chk($sformatf("R1 tokens vc%0d", v), tok(v), DEPTH);

      // Token deduction, adaptive choice, occupancy
      send(0, 2'd0, 3'd7, w);
      chk("R5 tie goes to vc0", int'(grant_vc), 0);
      chk("R2 vc0 after 8 chunks", tok(0), 8);
      send(1, 2'd0, 3'd0, w);
      chk("R7 wait after 8-chunk grant", w, 8);
      chk("R5 larger vc1 chosen", int'(grant_vc), 1);
      chk("R2 vc1 after 1 chunk", tok(1), 15);
      send(2, 2'd0, 3'd7, w);
      chk("R7 back-to-back after 1 chunk", w, 1);
      chk("R5 vc1 holds more", int'(grant_vc), 1);
      send(3, 2'd0, 3'd7, w);
      chk("R2 exact fit granted on vc0", int'(grant_vc), 0);
      chk("R2 vc0 emptied", tok(0), 0);
      send(0, 2'd0, 3'd7, w);
      chk("R6 fallback to escape", int'(grant_vc), 2);
      chk("R2 escape after 8 chunks", tok(2), 8);
      send(1, 2'd1, 3'd7, w);
      chk("R9 escape class on vc2", int'(grant_vc), 2);
      chk("R2 escape emptied", tok(2), 0);
      send(2, 2'd0, 3'd0, w);
      chk("R6 no fallback when vc1 fits", int'(grant_vc), 1);
      chk("R2 vc1 now 6", tok(1), 6);

      // R10: starved escape head must not block another input
      req_valid[0] = 1'b1; req_class[1:0] = 2'd1; req_len[2:0] = 3'd0;
      req_valid[3] = 1'b1; req_class[7:6] = 2'd0; req_len[11:9] = 3'd0;
      w = 0;
      do begin @(posedge clk); @(negedge clk); w++; end while (!grant_valid && w < 40);
      chk("R10 other input granted", int'(grant_idx), 3);
      req_valid[3] = 1'b0;
      w = 0;
      repeat (4) begin @(posedge clk); @(negedge clk); if (grant_valid) w++; end
      chk("R2 starved escape head not granted", w, 0);
      ret_valid = 1'b1; ret_vc = 2'd2;
      @(posedge clk); @(negedge clk);
      ret_valid = 1'b0;
      chk("R8 escape return counted", tok(2), 1);
      chk("R2 no grant in return cycle", int'(grant_valid), 0);
      @(posedge clk); @(negedge clk);
      chk("R2 escape head granted after return", int'(grant_valid), 1);
      chk("R10 granted idx", int'(grant_idx), 0);
      req_valid[0] = 1'b0;

      // R8 saturation and accumulation
      ret_valid = 1'b1; ret_vc = 2'd3;
      @(posedge clk); @(negedge clk);
      chk("R8 full vc3 saturates", tok(3), DEPTH);
      ret_vc = 2'd0;
      repeat (3) begin @(posedge clk); @(negedge clk); end
      ret_valid = 1'b0;
      chk("R8 vc0 three returns", tok(0), 3);

      // R4 rotation with held requests
      do_reset();
      req_valid = 4'b0111; req_class = 8'h15; req_len = '0;
      for (int k = 0; k < 4; k++) begin
         @(posedge clk); @(negedge clk);
         chk($sformatf("R4 rotation step %0d", k), int'(grant_idx), k % 3);
      end
      idle_inputs();

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule